// File: doc/BRIEF.md
# 3:2 Synchronous Clock-Ratio Transfer Bridge

This block moves data words in both directions between two clocks that share a common source and run in a fixed 3:2 frequency ratio. The two clocks have rising edges in common once every three fast cycles, which equals two slow cycles. No synchronizers are used. A phase tracker in the fast domain counts modulo 3 and decides which fast rising edges may launch words toward the slow domain and which may capture words arriving from it. Each launch edge is paired with exactly one capture edge, so every word crosses once at the slow domain's rate.

Each direction has a valid and data input on the launching side and a registered valid and data output on the capturing side. A valid bit travels with every word. The fast domain also exposes its launch and capture enables. The logic that feeds the fast-to-slow input uses them to know when a word is accepted.

The reset is synchronous and active low, and both domains sample it. It must be released so that the first rising edge that sees it high is a common edge of both clocks. That common edge is fast phase 0.

Top module: `ratio_bridge_3to2`

## Requirements
- R1: Fast rising edges are numbered with phases 0, 1 and 2. After reset release, the first fast edge is phase 0 and the phases then repeat 0,1,2. Between two fast edges, `f_launch_en` is high exactly when the next edge is phase 0 or phase 2, and `f_capture_en` is high exactly when the next edge is phase 0 or phase 1.
- R2: The fast-to-slow input is sampled only on fast edges where `f_launch_en` is high. A word presented with `f_in_valid` high before a phase-1 edge is ignored and never reaches `s_out_*`.
- R3: A word launched on fast phase 0 appears on `s_out_*` after the slow edge half a pattern later. A word launched on fast phase 2 appears after the slow edge that begins the next pattern.
- R4: The slow domain samples `s_in_*` on every slow rising edge. A word launched on the common edge appears on `f_out_*` after fast phase 1 of the same pattern. A word launched on the mid-pattern slow edge appears after fast phase 0 of the next pattern.
- R5: Each valid word appears on the output of its direction exactly once, in launch order, with no loss and no duplication. `f_out_valid` is high only in the fast cycle that follows a capture edge.
- R6: The fast launch register keeps its value through a phase-1 edge, so the word is stable when the paired slow capture edge arrives.
- R7: While `rst_n` is low, after a rising edge both output valids are 0 and the phase tracker is held at phase 0.
- R8: A legal launch edge with the input valid low delivers no word. The matching capture leaves the output valid at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| f_clk | input | 1 | Fast clock (3 parts of the 3:2 ratio) |
| s_clk | input | 1 | Slow clock, synchronous to `f_clk` |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both domains |
| f_in_valid | input | 1 | Fast-side word valid toward the slow domain |
| f_in_data | input | DATA_W | Fast-side word toward the slow domain |
| f_launch_en | output | 1 | Next fast edge may launch a word |
| f_capture_en | output | 1 | Next fast edge may capture a word |
| s_out_valid | output | 1 | Captured word valid in the slow domain |
| s_out_data | output | DATA_W | Captured word in the slow domain |
| s_in_valid | input | 1 | Slow-side word valid toward the fast domain |
| s_in_data | input | DATA_W | Slow-side word toward the fast domain |
| f_out_valid | output | 1 | Captured word valid in the fast domain, one fast cycle |
| f_out_data | output | DATA_W | Captured word in the fast domain |

## Verification
The bench builds the bridge with the default 16-bit data width. The fast clock runs at 125 MHz and the slow clock is scaled to two thirds of that, with both rising together at the start of each pattern. Random valid gaps in both directions, together with decoy words offered before phase-1 edges, reach every launch/capture pairing and both skipped edges. Every word records the clock edge on which it should be captured, so a capture on the wrong edge fails even when the order is correct.

// File: rtl/ratio_bridge_pkg.sv
// Package: shared phase type and phase rules for the 3:2 bridge.
// Assumes the fast clock has three rising edges per pattern, numbered 0..2,
// with phase 0 coinciding with a slow rising edge.
package ratio_bridge_pkg;

    typedef enum logic [1:0] {
        PH0 = 2'd0,
        PH1 = 2'd1,
        PH2 = 2'd2
    } phase_t;

    // Successor phase in the mod-3 sequence.
    function automatic phase_t phase_next(phase_t p);
        case (p)
            PH0:     return PH1;
            PH1:     return PH2;
            default: return PH0;
        endcase
    endfunction

    // Fast edges allowed to send words toward the slow domain.
    function automatic logic phase_may_launch(phase_t p);
        return (p == PH0) || (p == PH2);
    endfunction

    // Fast edges allowed to take words from the slow domain.
    function automatic logic phase_may_capture(phase_t p);
        return (p == PH0) || (p == PH1);
    endfunction

endpackage

// File: rtl/rb_phase_tracker.sv
// Module: mod-3 phase tracker for the fast domain.
// The counter holds the phase of the NEXT fast rising edge, so the enables
// it drives are valid for the registers that sample at that edge.
// Assumes rst_n is released so the first edge seeing it high is a common edge.
module rb_phase_tracker
    import ratio_bridge_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_t phase,
    output logic   launch_en,
    output logic   capture_en
);

    phase_t phase_q;

    // Advance the phase once per fast edge; reset parks it on phase 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH0;
        end else begin
            phase_q <= phase_next(phase_q);
        end
    end

    // Decode the legal launch and capture edges from the upcoming phase.
    always_comb begin
        launch_en  = phase_may_launch(phase_q);
        capture_en = phase_may_capture(phase_q);
    end

    assign phase = phase_q;

endmodule

// File: rtl/rb_launch_reg.sv
// Module: launch register for one crossing direction.
// On an enabled edge it takes the valid bit and, if valid, the data word;
// between enabled edges it holds, so the word stays stable until its capture.
// Assumes the enable is high only on edges paired with a capture edge.
module rb_launch_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              hold_valid,
    output logic [DATA_W-1:0] hold_data
);

    // Load on legal launch edges only; keep data when the slot is empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
            hold_data  <= '0;
        end else if (en) begin
            hold_valid <= in_valid;
            if (in_valid) begin
                hold_data <= in_data;
            end
        end
    end

endmodule

// File: rtl/rb_capture_reg.sv
// Module: capture register for one crossing direction.
// On an enabled edge it samples the paired launch register; on a skipped edge
// it drops valid so each word is presented for exactly one cycle.
// Assumes the source register is stable at every enabled edge.
module rb_capture_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    // Capture on legal edges; clear valid on skipped edges to avoid repeats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (en) begin
            out_valid <= src_valid;
            if (src_valid) begin
                out_data <= src_data;
            end
        end else begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/ratio_bridge_3to2.sv
// Module: two-way bridge between synchronous clocks in a 3:2 ratio.
// Fast-to-slow: launched on fast phases 0 and 2, captured on every slow edge.
// Slow-to-fast: launched on every slow edge, captured on fast phases 0 and 1.
// Assumes both clocks rise together at fast phase 0 and that rst_n is
// released so the first edge seeing it high is such a common edge.
module ratio_bridge_3to2
    import ratio_bridge_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              f_clk,
    input  logic              s_clk,
    input  logic              rst_n,
    input  logic              f_in_valid,
    input  logic [DATA_W-1:0] f_in_data,
    output logic              f_launch_en,
    output logic              f_capture_en,
    output logic              s_out_valid,
    output logic [DATA_W-1:0] s_out_data,
    input  logic              s_in_valid,
    input  logic [DATA_W-1:0] s_in_data,
    output logic              f_out_valid,
    output logic [DATA_W-1:0] f_out_data
);

    phase_t            f_phase;
    logic              f_hold_valid;
    logic [DATA_W-1:0] f_hold_data;
    logic              s_hold_valid;
    logic [DATA_W-1:0] s_hold_data;

    rb_phase_tracker u_phase (
        .clk        (f_clk),
        .rst_n      (rst_n),
        .phase      (f_phase),
        .launch_en  (f_launch_en),
        .capture_en (f_capture_en)
    );

    // Fast-to-slow direction.
    rb_launch_reg #(.DATA_W(DATA_W)) u_f_launch (
        .clk        (f_clk),
        .rst_n      (rst_n),
        .en         (f_launch_en),
        .in_valid   (f_in_valid),
        .in_data    (f_in_data),
        .hold_valid (f_hold_valid),
        .hold_data  (f_hold_data)
    );

    rb_capture_reg #(.DATA_W(DATA_W)) u_s_capture (
        .clk       (s_clk),
        .rst_n     (rst_n),
        .en        (1'b1),
        .src_valid (f_hold_valid),
        .src_data  (f_hold_data),
        .out_valid (s_out_valid),
        .out_data  (s_out_data)
    );

    // Slow-to-fast direction.
    rb_launch_reg #(.DATA_W(DATA_W)) u_s_launch (
        .clk        (s_clk),
        .rst_n      (rst_n),
        .en         (1'b1),
        .in_valid   (s_in_valid),
        .in_data    (s_in_data),
        .hold_valid (s_hold_valid),
        .hold_data  (s_hold_data)
    );

    rb_capture_reg #(.DATA_W(DATA_W)) u_f_capture (
        .clk       (f_clk),
        .rst_n     (rst_n),
        .en        (f_capture_en),
        .src_valid (s_hold_valid),
        .src_data  (s_hold_data),
        .out_valid (f_out_valid),
        .out_data  (f_out_data)
    );

endmodule

// File: rtl/ratio_bridge_3to2_chk.sv
// Checker: temporal rules of the fast-domain phase pattern and launch hold.
module ratio_bridge_3to2_chk #(
    parameter int DATA_W = 16
) (
    input logic              f_clk,
    input logic              rst_n,
    input logic              f_launch_en,
    input logic              f_capture_en,
    input logic              f_out_valid,
    input logic              f_hold_valid,
    input logic [DATA_W-1:0] f_hold_data
);

    // R1: at most one enable is skipped on any fast edge.
    assert_one_skip_R1: assert property (@(posedge f_clk) disable iff (!rst_n)
        f_launch_en || f_capture_en);

    // R1: the edge after the skipped launch is a launch-only edge.
    assert_phase1_to_2_R1: assert property (@(posedge f_clk) disable iff (!rst_n)
        !f_launch_en |=> (f_launch_en && !f_capture_en));

    // R1: the edge after the skipped capture launches and captures.
    assert_phase2_to_0_R1: assert property (@(posedge f_clk) disable iff (!rst_n)
        !f_capture_en |=> (f_launch_en && f_capture_en));

    // R5: fast output valid only follows a capture edge.
    assert_valid_after_capture_R5: assert property (@(posedge f_clk) disable iff (!rst_n)
        f_out_valid |-> $past(f_capture_en));

    // R6: the launch register is unchanged across a skipped launch edge.
    assert_launch_hold_R6: assert property (@(posedge f_clk) disable iff (!rst_n)
        !f_launch_en |=> ($stable(f_hold_data) && $stable(f_hold_valid)));

endmodule

bind ratio_bridge_3to2 ratio_bridge_3to2_chk #(.DATA_W(DATA_W)) u_chk (
    .f_clk        (f_clk),
    .rst_n        (rst_n),
    .f_launch_en  (f_launch_en),
    .f_capture_en (f_capture_en),
    .f_out_valid  (f_out_valid),
    .f_hold_valid (f_hold_valid),
    .f_hold_data  (f_hold_data)
);

// File: tb/ratio_bridge_3to2_tb.sv
// Scoreboard bench: drivers queue each accepted word with the time of the
// edge that must capture it; monitors pop and compare data and capture time.
module ratio_bridge_3to2_tb;

    localparam int DATA_W = 16;
    localparam int NWORDS = 300;
    // Fast period 8 ns, slow period 12 ns; common rising edges at 4 + 24k.

    logic              f_clk = 1'b0;
    logic              s_clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              f_in_valid = 1'b0;
    logic [DATA_W-1:0] f_in_data = '0;
    logic              f_launch_en, f_capture_en;
    logic              s_out_valid;
    logic [DATA_W-1:0] s_out_data;
    logic              s_in_valid = 1'b0;
    logic [DATA_W-1:0] s_in_data = '0;
    logic              f_out_valid;
    logic [DATA_W-1:0] f_out_data;

    int checks = 0;
    int errors = 0;
    logic running = 1'b0;
    logic [1:0] bph = 2'd0;

    logic [DATA_W-1:0] q_fs_data[$];
    time               q_fs_time[$];
    logic [DATA_W-1:0] q_sf_data[$];
    time               q_sf_time[$];

    ratio_bridge_3to2 #(.DATA_W(DATA_W)) u_dut (
        .f_clk        (f_clk),
        .s_clk        (s_clk),
        .rst_n        (rst_n),
        .f_in_valid   (f_in_valid),
        .f_in_data    (f_in_data),
        .f_launch_en  (f_launch_en),
        .f_capture_en (f_capture_en),
        .s_out_valid  (s_out_valid),
        .s_out_data   (s_out_data),
        .s_in_valid   (s_in_valid),
        .s_in_data    (s_in_data),
        .f_out_valid  (f_out_valid),
        .f_out_data   (f_out_data)
    );

    initial begin
        #4;
        forever begin f_clk = 1'b1; #4; f_clk = 1'b0; #4; end
    end

    initial begin
        #4;
        forever begin s_clk = 1'b1; #6; s_clk = 1'b0; #6; end
    end

    // Bench phase model: phase of the next fast edge, as required by R1.
    always @(posedge f_clk) begin
        if (!rst_n) bph <= 2'd0;
        else        bph <= (bph == 2'd2) ? 2'd0 : bph + 2'd1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Fast-side driver: valid words on launch edges are queued; decoys before
    // phase-1 edges must be ignored (R2); idle launch slots cover R8.
    task automatic drive_fast();
        int sent = 0;
        logic [DATA_W-1:0] seq = 16'h1000;
        while (sent < NWORDS) begin
            @(negedge f_clk);
            if (bph == 2'd1) begin
                f_in_valid = 1'b1;
                f_in_data  = 16'hDEAD;
            end else if (($urandom % 4) != 0) begin
                f_in_valid = 1'b1;
                f_in_data  = seq;
                q_fs_data.push_back(seq);
                // R3: phase 0 pairs with the slow edge 12 ns later,
                // phase 2 with the next common edge 8 ns later.
                q_fs_time.push_back($time + 4 + ((bph == 2'd0) ? 12 : 8));
                seq++;
                sent++;
            end else begin
                f_in_valid = 1'b0;
                f_in_data  = 16'hBEEF;
            end
        end
        @(negedge f_clk);
        f_in_valid = 1'b0;
    endtask

    // Slow-side driver: every slow edge launches (R4).
    task automatic drive_slow();
        int sent = 0;
        logic [DATA_W-1:0] seq = 16'h5000;
        while (sent < NWORDS) begin
            @(negedge s_clk);
            if (($urandom % 4) != 0) begin
                s_in_valid = 1'b1;
                s_in_data  = seq;
                q_sf_data.push_back(seq);
                // R4: common-edge launch pairs with phase 1 (+8 ns),
                // mid-pattern launch with the next phase 0 (+12 ns).
                q_sf_time.push_back($time + 6 +
                    (((($time + 6) - 4) % 24 == 0) ? 8 : 12));
                seq++;
                sent++;
            end else begin
                s_in_valid = 1'b0;
                s_in_data  = 16'hCAFE;
            end
        end
        @(negedge s_clk);
        s_in_valid = 1'b0;
    endtask

    // Fast monitor: enable pattern (R1) and slow-to-fast words (R4, R5).
    always @(negedge f_clk) begin
        if (running) begin
            check(f_launch_en == (bph != 2'd1), "R1", "f_launch_en",
                  f_launch_en, bph != 2'd1);
            check(f_capture_en == (bph != 2'd2), "R1", "f_capture_en",
                  f_capture_en, bph != 2'd2);
            if (f_out_valid) begin
                if (q_sf_data.size() == 0) begin
                    check(1'b0, "R5", "unexpected fast word", f_out_data, 0);
                end else begin
                    logic [DATA_W-1:0] ed;
                    time et;
                    ed = q_sf_data.pop_front();
                    et = q_sf_time.pop_front();
                    check(f_out_data == ed, "R5", "fast word data", f_out_data, ed);
                    check(($time - 4) == et, "R4", "fast capture time", $time - 4, et);
                end
            end
        end
    end

    // Slow monitor: fast-to-slow words (R2, R3, R5, R8).
    always @(negedge s_clk) begin
        if (running && s_out_valid) begin
            if (q_fs_data.size() == 0) begin
                check(1'b0, "R5", "unexpected slow word", s_out_data, 0);
            end else begin
                logic [DATA_W-1:0] ed;
                time et;
                ed = q_fs_data.pop_front();
                et = q_fs_time.pop_front();
                check(s_out_data == ed, "R2", "slow word data", s_out_data, ed);
                check(($time - 6) == et, "R3", "slow capture time", $time - 6, et);
            end
        end
    end

    initial begin
        // R7: drive reset with busy inputs, check cleared outputs.
        f_in_valid = 1'b1; f_in_data = 16'h7777;
        s_in_valid = 1'b1; s_in_data = 16'h6666;
        repeat (4) @(negedge f_clk);
        check(s_out_valid == 1'b0, "R7", "s_out_valid in reset", s_out_valid, 0);
        check(f_out_valid == 1'b0, "R7", "f_out_valid in reset", f_out_valid, 0);
        check(f_launch_en && f_capture_en, "R7", "phase 0 enables in reset",
              {f_launch_en, f_capture_en}, 3);
        f_in_valid = 1'b0;
        s_in_valid = 1'b0;
        // Release after the fast edge at 44 so the first high edge is 52.
        wait ($time >= 48);
        rst_n   = 1'b1;
        running = 1'b1;
        fork
            drive_fast();
            drive_slow();
        join
        repeat (12) @(negedge s_clk);
        check(q_fs_data.size() == 0, "R5", "fast-to-slow words lost",
              q_fs_data.size(), 0);
        check(q_sf_data.size() == 0, "R5", "slow-to-fast words lost",
              q_sf_data.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule